// File: doc/BRIEF.md
# Retransmit-capable synchronous FIFO with partial reset

A single-clock first-in first-out buffer with a 36-bit data path. It has two read behaviours, and the master reset chooses between them. In standard mode each word leaves only on an enabled read edge, and two active-low flags report empty and full. In first-word-fall-through mode the oldest word is presented on the output without a request, and the same two flag pins report output-ready and input-ready, both active low. Three occupancy flags, almost-empty, almost-full and half-full, are computed from two offset registers. Master reset loads a default into those registers, and they can be reloaded in parallel afterwards.

An asynchronous partial reset empties the buffer and clears the output register. It keeps the selected read mode, the retransmit latency and both offsets, so a running system can flush the queue without reprogramming. A retransmit request moves the read pointer back to location zero so the stored words can be read again. The read flag shows the rewind in progress for one cycle (zero-latency mode) or two cycles (normal-latency mode).

Top module: `fifo_rt`

## Requirements
- R1: While `mrst_n` is low, each clock edge captures `mode_fwft_i` (1 = fall-through, 0 = standard) and `lat_zero_i` (1 = zero-latency retransmit), and loads DEF_OFFSET into both offsets. After master reset the buffer is empty and `dout` is zero.
- R2: Standard mode: a write with `wen_n` low stores `din`. A read with `ren_n` low puts the oldest word on `dout` after that edge. `rd_flag_n` is 0 when the buffer is empty and 1 otherwise. `wr_flag_n` is 0 when the buffer holds DEPTH words and 1 otherwise.
- R3: Fall-through mode: a word written into an empty buffer appears on `dout` one edge after the write edge, with no read enable. `rd_flag_n` is 0 while a valid word is presented. `wr_flag_n` is 1 when occupancy equals DEPTH and 0 otherwise. Each `ren_n`-low edge advances to the next word.
- R4: A write when full and a read when empty are ignored. The pointers do not move and `dout` holds its value.
- R5: `hf_n` is 0 exactly when occupancy exceeds DEPTH/2.
- R6: `ae_n` is 0 when occupancy is at or below the empty offset. `af_n` is 0 when free space is at or below the full offset. With `off_load` high, an edge writes `off_val` into the empty offset (`off_sel`=0) or into the full offset (`off_sel`=1).
- R7: `prst_n` low immediately, without a clock, empties the buffer and zeroes `dout`. This gives `ae_n`=0, `af_n`=1, `hf_n`=1, and the flag-pin levels of an empty buffer.
- R8: Partial reset leaves the read mode, the latency mode and both offsets unchanged.
- R9: A retransmit starts on an edge with `rt_n` low and `wen_n` high. In normal-latency mode `ren_n` must also be high; otherwise the request is ignored.
- R10: Standard retransmit: `rd_flag_n` reads 0 during the setup. Afterwards each read with `ren_n` low returns words from location 0 onward.
- R11: Fall-through retransmit: `rd_flag_n` reads 1 during the setup. When it returns to 0, the word at location 0 is already on `dout`.
- R12: The setup lasts two cycles in normal-latency mode and one cycle in zero-latency mode.
- R13: Writes during the setup are ignored. After the rewind, occupancy equals the number of words written since the last reset (DEPTH if the write pointer has wrapped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| mode_fwft_i | input | 1 | Read mode select, sampled during master reset |
| lat_zero_i | input | 1 | Retransmit latency select, sampled during master reset |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit request, active low |
| din | input | DW | Write data |
| off_load | input | 1 | Offset load strobe |
| off_sel | input | 1 | 0 = empty offset, 1 = full offset |
| off_val | input | CW | Offset value to load |
| dout | output | DW | Output register |
| rd_flag_n | output | 1 | Empty (standard) or output-ready (fall-through) flag |
| wr_flag_n | output | 1 | Full (standard) or input-ready (fall-through) flag |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
The hardest case to reach is a write attempted during the retransmit setup. It has to be seen as ignored, and the recomputed occupancy has to be confirmed, even though neither is visible directly. The bench leaves the buffer partly filled after a partial reset, so a stray write could succeed. It reads part of the data, then drives a write in the busy cycle. It then drains the buffer from location zero and checks the word count and the point where the empty flag returns. Partial reset is checked between clock edges to show that it acts asynchronously.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
   typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;
   typedef enum logic {RT_NORMAL = 1'b0, RT_ZERO = 1'b1} rt_lat_e;
   localparam int unsigned RT_NORMAL_CYC = 2;
   localparam int unsigned RT_ZERO_CYC = 1;
endpackage

// File: rtl/fifo_rt_ram.sv
module fifo_rt_ram #(
   parameter int unsigned DW = 36,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_rt_ptr.sv
module fifo_rt_ptr #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          rewind,
   input  logic          inc,
   output logic [AW-1:0] ptr,
   output logic          wrap
);
   logic          at_end;
   logic [AW-1:0] nxt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign at_end = &ptr;
      assign nxt    = ptr + AW'(1);
   end else begin : g_any
      assign at_end = (ptr == AW'(DEPTH - 1));
      assign nxt    = at_end ? '0 : ptr + AW'(1);
   end

   assign wrap = inc && at_end;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     ptr <= '0;
      else if (rewind) ptr <= '0;
      else if (inc)    ptr <= nxt;
   end
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
   import fifo_rt_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  rd_mode_e      mode,
   input  logic [CW-1:0] occ,
   input  logic [CW-1:0] mcount,
   input  logic          head_vld,
   input  logic          busy,
   input  logic [CW-1:0] off_ae,
   input  logic [CW-1:0] off_af,
   output logic          rd_flag_n,
   output logic          wr_flag_n,
   output logic          ae_n,
   output logic          af_n,
   output logic          hf_n
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

   logic          full;
   logic [CW-1:0] space;

   assign full  = (occ == FULL_CNT);
   assign space = FULL_CNT - occ;

   always_comb begin
      if (mode == RD_FWFT) begin
         rd_flag_n = !(head_vld && !busy);
         wr_flag_n = full;
      end else begin
         rd_flag_n = !busy && (mcount != '0);
         wr_flag_n = !full;
      end
   end

   assign hf_n = !(occ > HALF_CNT);
   assign ae_n = !(occ <= off_ae);
   assign af_n = !(space <= off_af);
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
   import fifo_rt_pkg::*;
#(
   parameter int unsigned DW = 36,
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned DEF_OFFSET = 127,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          mode_fwft_i,
   input  logic          lat_zero_i,
   input  logic          wen_n,
   input  logic          ren_n,
   input  logic          rt_n,
   input  logic [DW-1:0] din,
   input  logic          off_load,
   input  logic          off_sel,
   input  logic [CW-1:0] off_val,
   output logic [DW-1:0] dout,
   output logic          rd_flag_n,
   output logic          wr_flag_n,
   output logic          ae_n,
   output logic          af_n,
   output logic          hf_n
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 4) begin : g_bad_depth
      $error("fifo_rt: DEPTH must be at least 4");
   end
   if (DEF_OFFSET >= DEPTH) begin : g_bad_offset
      $error("fifo_rt: DEF_OFFSET must be below DEPTH");
   end
   if (DW < 1) begin : g_bad_width
      $error("fifo_rt: DW must be positive");
   end

   logic          arst_n;
   rd_mode_e      mode_q;
   rt_lat_e       lat_q;
   logic [CW-1:0] off_ae_q, off_af_q;
   logic [CW-1:0] mcount_q, occ;
   logic          head_vld_q, wrapped_q;
   logic [1:0]    rt_cnt_q;
   logic          busy, rt_go, wr_do, rd_std, fetch, pop, mem_rd;
   logic [AW-1:0] wptr, rptr;
   logic          wwrap, rwrap_unused;
   logic [DW-1:0] rdata;

   assign arst_n = mrst_n & prst_n;

   // configuration: captured only under master reset, survives partial reset
   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q   <= rd_mode_e'(mode_fwft_i);
         lat_q    <= rt_lat_e'(lat_zero_i);
         off_ae_q <= CW'(DEF_OFFSET);
         off_af_q <= CW'(DEF_OFFSET);
      end else if (off_load) begin
         if (off_sel) off_af_q <= off_val;
         else         off_ae_q <= off_val;
      end
   end

   assign busy = (rt_cnt_q != 2'd0);
   assign occ  = mcount_q + CW'(head_vld_q);

   assign rt_go  = !rt_n && !busy && wen_n && (ren_n || (lat_q == RT_ZERO));
   assign wr_do  = !wen_n && !busy && !rt_go && (occ < FULL_CNT);
   assign rd_std = (mode_q == RD_STD) && !ren_n && !busy && !rt_go
                   && (mcount_q != '0);
   assign pop    = (mode_q == RD_FWFT) && head_vld_q && !ren_n && !busy && !rt_go;
   assign fetch  = (mode_q == RD_FWFT) && !rt_go && (mcount_q != '0)
                   && (rt_cnt_q <= 2'd1) && (!head_vld_q || pop);
   assign mem_rd = rd_std || fetch;

   fifo_rt_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (wr_do),
      .waddr (wptr),
      .wdata (din),
      .raddr (rptr),
      .rdata (rdata)
   );

   fifo_rt_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk    (clk),
      .arst_n (arst_n),
      .rewind (1'b0),
      .inc    (wr_do),
      .ptr    (wptr),
      .wrap   (wwrap)
   );

   fifo_rt_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk    (clk),
      .arst_n (arst_n),
      .rewind (rt_go),
      .inc    (mem_rd),
      .ptr    (rptr),
      .wrap   (rwrap_unused)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         mcount_q   <= '0;
         head_vld_q <= 1'b0;
         wrapped_q  <= 1'b0;
         rt_cnt_q   <= 2'd0;
         dout       <= '0;
      end else begin
         if (wwrap) wrapped_q <= 1'b1;
         if (rt_go) begin
            mcount_q   <= wrapped_q ? FULL_CNT : CW'(wptr);
            head_vld_q <= 1'b0;
            rt_cnt_q   <= (lat_q == RT_ZERO) ? 2'(RT_ZERO_CYC) : 2'(RT_NORMAL_CYC);
         end else begin
            mcount_q <= mcount_q + CW'(wr_do) - CW'(mem_rd);
            if (busy) rt_cnt_q <= rt_cnt_q - 2'd1;
            if (fetch)    head_vld_q <= 1'b1;
            else if (pop) head_vld_q <= 1'b0;
         end
         if (mem_rd) dout <= rdata;
      end
   end

   fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
      .mode      (mode_q),
      .occ       (occ),
      .mcount    (mcount_q),
      .head_vld  (head_vld_q),
      .busy      (busy),
      .off_ae    (off_ae_q),
      .off_af    (off_af_q),
      .rd_flag_n (rd_flag_n),
      .wr_flag_n (wr_flag_n),
      .ae_n      (ae_n),
      .af_n      (af_n),
      .hf_n      (hf_n)
   );

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!arst_n)
      occ <= FULL_CNT);

   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!arst_n)
      (mode_q == RD_STD && mcount_q == '0 && !rt_go) |=> $stable(rptr));

   a_r13_no_write_in_setup: assert property (@(posedge clk) disable iff (!arst_n)
      busy |=> $stable(wptr));

   a_r10_rewind_to_zero: assert property (@(posedge clk) disable iff (!arst_n)
      rt_go |=> (rptr == '0));

   a_r7_prst_empties: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(prst_n) |-> (occ == '0 && dout == '0));

   a_r12_setup_length: assert property (@(posedge clk) disable iff (!arst_n)
      (rt_go && lat_q == RT_ZERO) |=> (busy ##1 !busy));
endmodule

// File: tb/fifo_rt_bench.sv
`timescale 1ns/1ps
module fifo_rt_bench;
   localparam int DW = 36;
   localparam int DEPTH = 16;
   localparam int DEFO = 3;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic mrst_n = 1'b0, prst_n = 1'b1, mode_fwft_i = 1'b0, lat_zero_i = 1'b0;
   logic wen_n = 1'b1, ren_n = 1'b1, rt_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic off_load = 1'b0, off_sel = 1'b0;
   logic [CW-1:0] off_val = '0;
   logic [DW-1:0] dout;
   logic rd_flag_n, wr_flag_n, ae_n, af_n, hf_n;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fifo_rt #(.DW(DW), .DEPTH(DEPTH), .DEF_OFFSET(DEFO)) u_fifo_rt (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_fwft_i(mode_fwft_i),
      .lat_zero_i(lat_zero_i), .wen_n(wen_n), .ren_n(ren_n), .rt_n(rt_n),
      .din(din), .off_load(off_load), .off_sel(off_sel), .off_val(off_val),
      .dout(dout), .rd_flag_n(rd_flag_n), .wr_flag_n(wr_flag_n),
      .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
   );

   function automatic logic [DW-1:0] pat(int i);
      return DW'(i) * 36'h0_0F0F_0F0F + 36'h3_0000_0001;
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // occupancy flags from the requirement arithmetic (offsets ae/af)
   task automatic chk_occ(string req, int occ, int oae, int oaf);
      chk({req, " hf"}, DW'(hf_n), DW'(!(occ > DEPTH / 2)));
      chk({req, " ae"}, DW'(ae_n), DW'(!(occ <= oae)));
      chk({req, " af"}, DW'(af_n), DW'(!((DEPTH - occ) <= oaf)));
   endtask

   task automatic mreset(bit fwft, bit zlat);
      mode_fwft_i = fwft;
      lat_zero_i = zlat;
      mrst_n = 1'b0;
      repeat (3) step();
      mrst_n = 1'b1;
      mode_fwft_i = ~fwft;
      lat_zero_i = ~zlat;
   endtask

   task automatic wr(int i);
      din = pat(i);
      wen_n = 1'b0;
      step();
      wen_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      // ---------- standard mode, normal latency ----------
      mreset(1'b0, 1'b0);
      chk("R1 reset rd_flag", DW'(rd_flag_n), 0);
      chk("R1 reset wr_flag", DW'(wr_flag_n), 1);
      chk("R1 reset dout", dout, 0);
      chk_occ("R1 reset", 0, DEFO, DEFO);

      for (int k = 1; k <= DEPTH; k++) begin
         wr(k - 1);
         chk("R2 fill rd_flag", DW'(rd_flag_n), 1);
         chk("R2 fill wr_flag", DW'(wr_flag_n), DW'(k != DEPTH));
         chk_occ("R5 R6 fill", k, DEFO, DEFO);
      end
      wr(99); // R4: write when full is ignored
      chk("R2 std no fall-through", dout, 0);
      for (int i = 0; i < DEPTH; i++) begin
         ren_n = 1'b0;
         step();
         chk("R2 read data", dout, pat(i));
      end
      chk("R4 empty after DEPTH reads", DW'(rd_flag_n), 0);
      step();
      chk("R4 read on empty holds dout", dout, pat(DEPTH - 1));
      ren_n = 1'b1;

      // ---------- offset load, partial reset ----------
      off_load = 1'b1; off_sel = 1'b0; off_val = CW'(5);
      step();
      off_load = 1'b0;
      for (int i = 0; i < 6; i++) wr(20 + i);
      chk_occ("R6 loaded ae offset", 6, 5, DEFO);
      prst_n = 1'b0;
      #1;
      chk("R7 async dout", dout, 0);
      chk("R7 async rd_flag", DW'(rd_flag_n), 0);
      chk("R7 async wr_flag", DW'(wr_flag_n), 1);
      chk_occ("R7 async", 0, 5, DEFO);
      step();
      prst_n = 1'b1;
      step();
      for (int i = 0; i < 5; i++) wr(40 + i);
      chk("R8 ae offset kept", DW'(ae_n), 0);
      chk("R8 std mode kept", dout, 0);
      wr(45);
      chk("R8 ae offset kept above", DW'(ae_n), 1);

      // ---------- retransmit in standard mode ----------
      ren_n = 1'b0;
      step();
      chk("R2 read after prst", dout, pat(40));
      rt_n = 1'b0; // R9: ren low blocks normal-latency retransmit
      step();
      rt_n = 1'b1;
      ren_n = 1'b1;
      chk("R9 rt ignored while reading", DW'(rd_flag_n), 1);
      chk("R9 read proceeded", dout, pat(41));
      rt_n = 1'b0;
      step();
      rt_n = 1'b1;
      chk("R10 R12 setup cycle 1", DW'(rd_flag_n), 0);
      din = pat(77); wen_n = 1'b0; // R13: write during setup
      step();
      wen_n = 1'b1;
      chk("R10 R12 setup cycle 2", DW'(rd_flag_n), 0);
      step();
      chk("R12 released after two", DW'(rd_flag_n), 1);
      chk_occ("R13 recomputed count", 6, 5, DEFO);
      for (int i = 0; i < 6; i++) begin
         ren_n = 1'b0;
         step();
         chk("R10 reread from zero", dout, pat(40 + i));
      end
      ren_n = 1'b1;
      chk("R13 setup write ignored", DW'(rd_flag_n), 0);

      // ---------- fall-through, zero latency ----------
      mreset(1'b1, 1'b1);
      chk("R1 fwft reset or", DW'(rd_flag_n), 1);
      chk("R1 fwft reset ir", DW'(wr_flag_n), 0);
      wr(100);
      chk("R3 not yet presented", DW'(rd_flag_n), 1);
      step();
      chk("R3 presented", DW'(rd_flag_n), 0);
      chk("R3 first word", dout, pat(100));
      for (int i = 1; i < 4; i++) wr(100 + i);
      chk_occ("R1 R6 default offset", 4, DEFO, DEFO);
      ren_n = 1'b0;
      step();
      chk("R3 advance", dout, pat(101));
      rt_n = 1'b0; // R9: ren low allowed in zero latency
      step();
      rt_n = 1'b1;
      ren_n = 1'b1;
      chk("R11 setup or high", DW'(rd_flag_n), 1);
      step();
      chk("R12 zero latency release", DW'(rd_flag_n), 0);
      chk("R11 word zero presented", dout, pat(100));
      for (int i = 0; i < DEPTH - 5; i++) wr(200 + i);
      chk("R3 ir before full", DW'(wr_flag_n), 0);
      wr(300);
      chk("R3 ir at full", DW'(wr_flag_n), 1);

      // ---------- fall-through, normal latency ----------
      mreset(1'b1, 1'b0);
      wr(500);
      wr(501);
      rt_n = 1'b0;
      step();
      rt_n = 1'b1;
      chk("R11 R12 normal setup 1", DW'(rd_flag_n), 1);
      step();
      chk("R11 R12 normal setup 2", DW'(rd_flag_n), 1);
      step();
      chk("R12 normal release", DW'(rd_flag_n), 0);
      chk("R11 normal word zero", dout, pat(500));

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule